// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

The block scans a 4x4 matrix of switches. Every column line has a pull-up. The block drives the row lines active-low, one row at a time, and reads the column lines. A key that is pressed joins its row to its column. So when the scanner pulls that row low, the column that carries the key reads low for as long as the key is held. The scanner steps the low level through row 0, row 1, row 2 and row 3, and then starts again at row 0. It stays on each row for a set number of clocks. When it finds a low column, it stops stepping and watches that single row and column. It reports the key only after the key has held steady for a full debounce interval.

A report is a one-clock strobe together with a 4-bit hex code that gives the key position. After a report, the scanner drives every row low. It then waits until the whole matrix has been quiet for one debounce interval before it scans again. A key that is held down therefore gives exactly one report, and switch chatter on release gives none. The column inputs come from outside and have no fixed timing, so they pass through a two-stage synchroniser before any logic uses them.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted and straight after it, `row_out_n` is 4'b1110 (row 0 low), `key_valid` is 0 and `key_code` is 0.
- R2: With no key pressed, exactly one row line is low at a time. The low line moves from row 0 to row 1, row 2, row 3 and back to row 0. It stays on each row for DWELL_CYCLES clocks.
- R3: Each column input passes through two flip-flops before it is used. A low column is noticed only on the last clock of a row's dwell interval. A press that is gone before that sample is never reported.
- R4: Once a low column is found, the row drive stops moving. The key is reported when its column has read low on DEBOUNCE_CYCLES consecutive synchronised samples.
- R5: If the watched column reads high during the debounce interval, nothing is reported. Scanning then goes on from the next row.
- R6: A report raises `key_valid` for exactly one clock, with `key_code` = row*4 + column. Row 0 column 0 gives 0 and row 3 column 3 gives 15. `key_code` changes only in a report cycle and holds its value between reports.
- R7: If several columns are low on the same row at the sample, the column with the lowest index is the one taken.
- R8: From the report cycle onward, all row lines are driven low. Scanning restarts at row 0 only after DEBOUNCE_CYCLES consecutive synchronised samples with every column high. A key that is still held produces no further report.
- R9: During the release wait, any low column sample restarts the count of quiet samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released in step with the clock. |
| col_in | input | COLS (4) | Column lines from the matrix, pulled up. Low means a key is joined to a driven row. |
| row_out_n | output | ROWS (4) | Row drive lines, active-low |
| key_valid | output | 1 | One-clock strobe for a reported key |
| key_code | output | log2(ROWS*COLS) (4) | Code of the last reported key, row*COLS + column |

## Verification
The assertions assume that a column is only ever pulled low through a row the scanner is driving low, as a real switch matrix behaves. They also assume that reset is released away from the clock edge. Under those assumptions they check one-hot row rotation, single-clock strobes, the all-rows-low release phase, and the minimum spacing between two reports. The stimulus keeps to these assumptions by deriving `col_in` from a model of the matrix: it holds a set of pressed switches and combines them with the live row drive, and the set changes only on falling clock edges. The scenarios cover long holds, short bursts below the debounce length, one-clock glitches, two keys on one row, and a release that is interrupted by another press.

// File: rtl/kps_pkg.sv
package kps_pkg;
  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_HOLDOFF = 2'd2
  } kps_state_e;
endpackage

// File: rtl/kps_sync.sv
module kps_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  // Idle level of a pulled-up column is high, so both stages reset to ones.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b1;
        stage2_q[i] <= 1'b1;
      end else begin
        stage1_q[i] <= d[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/kps_col_pick.sv
module kps_col_pick #(
  parameter int COLS = 4,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [COLS-1:0] col_n,
  output logic            any_low,
  output logic [CW-1:0]   idx
);
  // Lowest-numbered low column wins: the loop runs downward and the last hit stays.
  always_comb begin
    any_low = ~&col_n;
    idx     = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (!col_n[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/kps_ctrl.sv
module kps_ctrl
  import kps_pkg::*;
#(
  parameter int ROWS            = 4,
  parameter int COLS            = 4,
  parameter int DWELL_CYCLES    = 50,
  parameter int DEBOUNCE_CYCLES = 250000,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int KW  = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS-1:0] col_s,
  input  logic            pick_any,
  input  logic [CW-1:0]   pick_idx,
  output logic [ROWS-1:0] row_n,
  output logic            key_valid,
  output logic [KW-1:0]   key_code
);
  localparam int DWW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam int DBW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [DWW-1:0] DWELL_LAST = DWW'(DWELL_CYCLES - 1);
  localparam logic [DBW-1:0] DEB_LAST   = DBW'(DEBOUNCE_CYCLES - 1);
  localparam logic [RW-1:0]  ROW_LAST   = RW'(ROWS - 1);

  kps_state_e     state_q, state_d;
  logic [RW-1:0]  row_q, row_d, row_next;
  logic [DWW-1:0] dwell_q, dwell_d;
  logic [DBW-1:0] cnt_q, cnt_d;
  logic [CW-1:0]  col_q, col_d;
  logic           valid_q, valid_d;
  logic [KW-1:0]  code_q, code_d;
  logic           code_en;

  assign row_next = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    dwell_d = dwell_q;
    cnt_d   = cnt_q;
    col_d   = col_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_SCAN: begin
        if (dwell_q == DWELL_LAST) begin
          dwell_d = '0;
          if (pick_any) begin
            state_d = ST_CONFIRM;
            col_d   = pick_idx;
            cnt_d   = '0;
          end else begin
            row_d = row_next;
          end
        end else begin
          dwell_d = dwell_q + 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (!col_s[col_q]) begin
          if (cnt_q == DEB_LAST) begin
            valid_d = 1'b1;
            state_d = ST_HOLDOFF;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          state_d = ST_SCAN;
          row_d   = row_next;
          dwell_d = '0;
        end
      end
      ST_HOLDOFF: begin
        if (&col_s) begin
          if (cnt_q == DEB_LAST) begin
            state_d = ST_SCAN;
            row_d   = '0;
            dwell_d = '0;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0;
        end
      end
      default: begin
        state_d = ST_SCAN;
        row_d   = '0;
        dwell_d = '0;
        cnt_d   = '0;
      end
    endcase
  end

  assign code_en = valid_d;
  assign code_d  = KW'(row_q) * KW'(COLS) + KW'(col_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SCAN;
      row_q   <= '0;
      dwell_q <= '0;
      cnt_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      dwell_q <= dwell_d;
      cnt_q   <= cnt_d;
      col_q   <= col_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  // Row decoder: the selected row is low, and every row is low during hold-off.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_n[r] = ~((state_q == ST_HOLDOFF) | (row_q == RW'(r)));
  end

  assign key_valid = valid_q;
  assign key_code  = code_q;
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS            = 4,
  parameter int COLS            = 4,
  parameter int DWELL_CYCLES    = 50,
  parameter int DEBOUNCE_CYCLES = 250000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [COLS-1:0]                col_in,
  output logic [ROWS-1:0]                row_out_n,
  output logic                           key_valid,
  output logic [$clog2(ROWS*COLS)-1:0]   key_code
);
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [COLS-1:0] col_s;
  logic            pick_any;
  logic [CW-1:0]   pick_idx;

  kps_sync #(.WIDTH(COLS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (col_in),
    .q    (col_s)
  );

  kps_col_pick #(.COLS(COLS)) u_pick (
    .col_n  (col_s),
    .any_low(pick_any),
    .idx    (pick_idx)
  );

  kps_ctrl #(
    .ROWS           (ROWS),
    .COLS           (COLS),
    .DWELL_CYCLES   (DWELL_CYCLES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_s    (col_s),
    .pick_any (pick_any),
    .pick_idx (pick_idx),
    .row_n    (row_out_n),
    .key_valid(key_valid),
    .key_code (key_code)
  );
endmodule

// File: rtl/kps_checker.sv
module kps_checker #(
  parameter int ROWS            = 4,
  parameter int COLS            = 4,
  parameter int DEBOUNCE_CYCLES = 250000
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ROWS-1:0]              row_out_n,
  input logic                         key_valid,
  input logic [$clog2(ROWS*COLS)-1:0] key_code
);
  localparam int GAP_MIN = 2 * DEBOUNCE_CYCLES;
  localparam int GW      = $clog2(GAP_MIN + 1) + 1;

  logic [GW-1:0] gap_q;

  // Clocks since the last strobe, saturating; starts saturated after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GW'(GAP_MIN);
    end else if (key_valid) begin
      gap_q <= '0;
    end else if (gap_q < GW'(GAP_MIN)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_out_n == '0) || ($countones(~row_out_n) == 1));

  assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(row_out_n) != '0) && (row_out_n != '0) && (row_out_n != $past(row_out_n)))
    |-> (row_out_n == {$past(row_out_n[ROWS-2:0]), $past(row_out_n[ROWS-1])}));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(key_code) |-> key_valid);

  assert_holdoff_rows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (row_out_n == '0));

  assert_report_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (gap_q >= GW'(GAP_MIN)));
endmodule

bind keypad_scanner kps_checker #(
  .ROWS           (ROWS),
  .COLS           (COLS),
  .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
) u_kps_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .row_out_n(row_out_n),
  .key_valid(key_valid),
  .key_code (key_code)
);

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  localparam int DW = 4;
  localparam int DB = 16;

  logic       clk;
  logic       rst_n;
  logic [3:0] col_in;
  logic [3:0] row_out_n;
  logic       key_valid;
  logic [3:0] key_code;
  logic [15:0] pressed;

  int n_checks;
  int n_fail;
  int got_codes[$];

  keypad_scanner #(
    .ROWS(4), .COLS(4), .DWELL_CYCLES(DW), .DEBOUNCE_CYCLES(DB)
  ) i_keypad_scanner (
    .clk(clk), .rst_n(rst_n), .col_in(col_in),
    .row_out_n(row_out_n), .key_valid(key_valid), .key_code(key_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Switch matrix: a column goes low when a pressed switch meets a low row.
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      col_in[c] = 1'b1;
      for (int r = 0; r < 4; r++) begin
        if (pressed[r*4+c] && !row_out_n[r]) col_in[c] = 1'b0;
      end
    end
  end

  // Behavioural reference: 0 scan, 1 confirm, 2 hold-off.
  int m_state, m_row, m_dwell, m_cnt, m_col, m_code;
  bit m_valid;
  logic [3:0] m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_row = 0; m_dwell = 0; m_cnt = 0; m_col = 0;
      m_code = 0; m_valid = 0; m_s1 = 4'hF; m_s2 = 4'hF;
    end else begin
      logic [3:0] cs;
      bit nv;
      int pick;
      cs = m_s2; m_s2 = m_s1; m_s1 = col_in;
      nv = 0;
      pick = -1;
      for (int c = 3; c >= 0; c--) if (!cs[c]) pick = c;
      case (m_state)
        0: begin
          if (m_dwell == DW - 1) begin
            m_dwell = 0;
            if (pick >= 0) begin m_state = 1; m_col = pick; m_cnt = 0; end
            else m_row = (m_row + 1) % 4;
          end else m_dwell++;
        end
        1: begin
          if (!cs[m_col]) begin
            if (m_cnt == DB - 1) begin
              nv = 1; m_code = m_row * 4 + m_col; m_state = 2; m_cnt = 0;
            end else m_cnt++;
          end else begin
            m_state = 0; m_row = (m_row + 1) % 4; m_dwell = 0;
          end
        end
        default: begin
          if (cs == 4'hF) begin
            if (m_cnt == DB - 1) begin m_state = 0; m_row = 0; m_dwell = 0; m_cnt = 0; end
            else m_cnt++;
          end else m_cnt = 0;
        end
      endcase
      m_valid = nv;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] exp_rows;
      exp_rows = (m_state == 2) ? 4'h0 : ~(4'b0001 << m_row);
      check(row_out_n == exp_rows, "R2 row drive", int'(row_out_n), int'(exp_rows));
      check(key_valid == m_valid, "R6 strobe", int'(key_valid), int'(m_valid));
      check(int'(key_code) == m_code, "R6 code", int'(key_code), m_code);
      if (key_valid) got_codes.push_back(int'(key_code));
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_codes(string req, int exp[$]);
    bit ok;
    ok = (got_codes.size() == exp.size());
    if (ok) foreach (exp[i]) if (got_codes[i] != exp[i]) ok = 0;
    check(ok, req, (got_codes.size() > 0) ? got_codes[0] : -1,
          (exp.size() > 0) ? exp[0] : -1);
    if (got_codes.size() != exp.size())
      check(0, {req, " count"}, got_codes.size(), exp.size());
    got_codes.delete();
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_checks = 0; n_fail = 0;
    pressed = '0;
    rst_n = 1'b0;
    wait_clk(5);
    // R1: reset values
    check(row_out_n == 4'b1110, "R1 rows", int'(row_out_n), 14);
    check(key_valid == 1'b0, "R1 strobe", int'(key_valid), 0);
    check(key_code == 4'd0, "R1 code", int'(key_code), 0);
    rst_n = 1'b1;
    wait_clk(1);
    check(row_out_n == 4'b1110, "R1 rows after release", int'(row_out_n), 14);

    // R2: idle scanning, no reports
    wait_clk(64);
    expect_codes("R2 idle", '{});

    // R4 / R6: single key row 2 col 1 -> 9
    pressed[9] = 1'b1; wait_clk(100); pressed = '0; wait_clk(60);
    expect_codes("R4 key 9", '{9});

    // R6 corners: row 3 col 3 -> 15, row 0 col 0 -> 0
    pressed[15] = 1'b1; wait_clk(100); pressed = '0; wait_clk(60);
    expect_codes("R6 key 15", '{15});
    pressed[0] = 1'b1; wait_clk(100); pressed = '0; wait_clk(60);
    expect_codes("R6 key 0", '{0});

    // R7: two keys on row 1 (cols 1 and 3) -> lowest column, code 5
    pressed[5] = 1'b1; pressed[7] = 1'b1; wait_clk(100); pressed = '0; wait_clk(60);
    expect_codes("R7 lowest column", '{5});

    // R5: press shorter than the debounce interval is never reported
    pressed[6] = 1'b1; wait_clk(10); pressed = '0; wait_clk(60);
    expect_codes("R5 short press", '{});

    // R3: one-clock glitch is not reported
    pressed[2] = 1'b1; wait_clk(1); pressed = '0; wait_clk(40);
    expect_codes("R3 glitch", '{});

    // R8: long hold gives one report only
    pressed[10] = 1'b1; wait_clk(300);
    check(row_out_n == 4'h0, "R8 rows low while held", int'(row_out_n), 0);
    pressed = '0; wait_clk(60);
    expect_codes("R8 held key", '{10});

    // R9: release interrupted by a new press restarts the quiet count
    pressed[12] = 1'b1; wait_clk(80); pressed = '0; wait_clk(8);
    pressed[12] = 1'b1; wait_clk(40); pressed = '0; wait_clk(60);
    expect_codes("R9 interrupted release", '{12});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule